// File: doc/BRIEF.md
# Banked Binary Point Register Slice

This block is the per-CPU register slice of an interrupt controller CPU interface. It stores, for each CPU, an 8-bit priority mask, two 3-bit binary point copies and a set of 32-bit active-priority words. Software reaches these through a simple read/write port that carries three things with each access: a 12-bit word offset, a CPU index and a secure/non-secure attribute.

When security extensions are present, the binary point is banked by the security attribute. A non-secure access to the binary point offset reaches the second copy. That same copy is also reachable as an aliased binary point at its own offset, but the alias reads as zero and ignores writes in two cases: when the controller lacks interrupt grouping (revision below 2), or when the access is non-secure with security extensions present.

Writes to the second copy never store a value below 1. Writes to the primary copy are stored unclamped. Offsets that decode to nothing read as zero and discard writes. Read data appears one cycle after the read strobe.

Top module: `bp_bank_regs`

## Requirements
- R1: After reset every CPU holds primary binary point 0, aliased binary point 1, priority mask 0 and all active-priority words 0.
- R2: Offset 0x004 reads and writes an 8-bit priority mask taken from wdata[7:0]. Bits [31:8] read as zero for every offset other than the active-priority words.
- R3: At offset 0x008, a secure access, or any access when security extensions are absent, reaches the primary copy. The stored value is wdata[2:0] with no lower bound.
- R4: At offset 0x008, a non-secure access with security extensions present reaches the aliased copy. The write stores max(wdata[2:0], 1) and leaves the primary copy unchanged.
- R5: Offset 0x01C reads as zero and ignores writes when cfg_rev is below 2.
- R6: Offset 0x01C reads as zero and ignores writes for a non-secure access while security extensions are present.
- R7: In all other cases, offset 0x01C reaches the aliased copy and a write stores max(wdata[2:0], 1). A secure access with security extensions present therefore reaches the non-secure binary point.
- R8: Offsets 0x0D0, 0x0D4, 0x0D8 and 0x0DC hold full 32-bit active-priority words. The word index is (offset - 0x0D0)/4.
- R9: All storage is replicated per CPU and selected by cpu_idx. An access never changes another CPU's state.
- R10: Every other offset, including unaligned ones, reads as zero and ignores writes.
- R11: rdata presents the addressed value one cycle after rd_en is high. It holds its value in cycles that follow no read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_rev | input | 2 | Controller revision; grouping exists when 2 or more |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset within the CPU interface |
| cpu_idx | input | 2 | CPU selecting the storage bank |
| acc_secure | input | 1 | Access is secure when high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
A write updates storage at the clock edge where wr_en is sampled, so it is visible to any read strobed in the next cycle. Read data is due exactly one edge after rd_en. The bench therefore drives each strobe for one cycle from the falling edge, and it samples rdata on the following falling edge, against a model of the banked storage held in bench functions. Hold behaviour is checked by idling, and by writing without reading, then confirming that rdata has not moved.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 32;
  localparam int BP_W   = 3;
  localparam int PMR_W  = 8;

  localparam logic [OFF_W-1:0] OFF_PMR  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_BP   = 12'h008;
  localparam logic [OFF_W-1:0] OFF_ABP  = 12'h01C;
  localparam logic [OFF_W-1:0] OFF_APR0 = 12'h0D0;

  localparam logic [BP_W-1:0] PRI_FLOOR = 3'd0;
  localparam logic [BP_W-1:0] ALI_FLOOR = 3'd1;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PMR,
    TGT_BP_PRI,
    TGT_BP_ALI,
    TGT_APR
  } tgt_e;

  // Keep the low binary-point bits and raise them to the copy's floor.
  function automatic logic [BP_W-1:0] clamp_bp(input logic [DATA_W-1:0] wd,
                                               input logic [BP_W-1:0] floor_v);
    logic [BP_W-1:0] v;
    v = wd[BP_W-1:0];
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Alias offset is hidden without grouping or for banked non-secure access.
  function automatic logic alias_hidden(input logic grouping,
                                        input logic sec_ext,
                                        input logic secure);
    return !grouping || (sec_ext && !secure);
  endfunction
endpackage

// File: rtl/bp_decode.sv
module bp_decode
  import bpr_pkg::*;
#(
  parameter int NUM_APR = 4,
  localparam int APR_IW = (NUM_APR > 1) ? $clog2(NUM_APR) : 1
) (
  input  logic [OFF_W-1:0]  addr,
  input  logic              secure,
  input  logic              sec_ext,
  input  logic              grouping,
  output tgt_e              tgt,
  output logic [APR_IW-1:0] apr_idx
);
  localparam logic [OFF_W-1:0] APR_END = OFF_APR0 + OFF_W'(4 * NUM_APR);

  logic             in_apr;
  logic [OFF_W-1:0] apr_off;

  assign apr_off = addr - OFF_APR0;
  assign in_apr  = (addr >= OFF_APR0) && (addr < APR_END) && (addr[1:0] == 2'b00);
  assign apr_idx = apr_off[2 +: APR_IW];

  always_comb begin
    tgt = TGT_NONE;
    if (addr == OFF_PMR) begin
      tgt = TGT_PMR;
    end else if (addr == OFF_BP) begin
      tgt = (sec_ext && !secure) ? TGT_BP_ALI : TGT_BP_PRI;
    end else if (addr == OFF_ABP) begin
      tgt = alias_hidden(grouping, sec_ext, secure) ? TGT_NONE : TGT_BP_ALI;
    end else if (in_apr) begin
      tgt = TGT_APR;
    end
  end
endmodule

// File: rtl/bp_cpu_bank.sv
module bp_cpu_bank
  import bpr_pkg::*;
#(
  parameter int NUM_APR = 4,
  localparam int APR_IW = (NUM_APR > 1) ? $clog2(NUM_APR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  tgt_e                      tgt,
  input  logic [APR_IW-1:0]         apr_idx,
  input  logic [DATA_W-1:0]         wdata,
  output logic [PMR_W-1:0]          pmr_q,
  output logic [BP_W-1:0]           bp_pri_q,
  output logic [BP_W-1:0]           bp_ali_q,
  output logic [NUM_APR*DATA_W-1:0] apr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmr_q    <= '0;
      bp_pri_q <= PRI_FLOOR;
      bp_ali_q <= ALI_FLOOR;
    end else if (we) begin
      if (tgt == TGT_PMR)    pmr_q    <= wdata[PMR_W-1:0];
      if (tgt == TGT_BP_PRI) bp_pri_q <= clamp_bp(wdata, PRI_FLOOR);
      if (tgt == TGT_BP_ALI) bp_ali_q <= clamp_bp(wdata, ALI_FLOOR);
    end
  end

  for (genvar w = 0; w < NUM_APR; w++) begin : g_apr
    logic hit;
    assign hit = we && (tgt == TGT_APR) && (apr_idx == APR_IW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   apr_q[w*DATA_W +: DATA_W] <= '0;
      else if (hit) apr_q[w*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/bp_read_mux.sv
module bp_read_mux
  import bpr_pkg::*;
#(
  parameter int NUM_APR = 4,
  localparam int APR_IW = (NUM_APR > 1) ? $clog2(NUM_APR) : 1
) (
  input  tgt_e                      tgt,
  input  logic [APR_IW-1:0]         apr_idx,
  input  logic [PMR_W-1:0]          pmr,
  input  logic [BP_W-1:0]           bp_pri,
  input  logic [BP_W-1:0]           bp_ali,
  input  logic [NUM_APR*DATA_W-1:0] apr,
  output logic [DATA_W-1:0]         rword
);
  always_comb begin
    rword = '0;
    case (tgt)
      TGT_PMR:    rword = DATA_W'(pmr);
      TGT_BP_PRI: rword = DATA_W'(bp_pri);
      TGT_BP_ALI: rword = DATA_W'(bp_ali);
      TGT_APR:    rword = apr[apr_idx*DATA_W +: DATA_W];
      default:    rword = '0;
    endcase
  end
endmodule

// File: rtl/bp_bank_regs.sv
module bp_bank_regs
  import bpr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_APR = 4,
  parameter int REV_W   = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int APR_IW = (NUM_APR > 1) ? $clog2(NUM_APR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sec_ext,
  input  logic [REV_W-1:0]  cfg_rev,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  addr,
  input  logic [CPU_W-1:0]  cpu_idx,
  input  logic              acc_secure,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              grouping;
  tgt_e              tgt;
  logic [APR_IW-1:0] apr_idx;
  logic              cpu_ok;

  // Named events for the checker
  logic wr_applied;
  logic wr_ignored;

  logic [PMR_W-1:0]          pmr_a    [NUM_CPU];
  logic [BP_W-1:0]           bp_pri_a [NUM_CPU];
  logic [BP_W-1:0]           bp_ali_a [NUM_CPU];
  logic [NUM_APR*DATA_W-1:0] apr_a    [NUM_CPU];

  logic [NUM_CPU*PMR_W-1:0]          pmr_vec;
  logic [NUM_CPU*BP_W-1:0]           bp_pri_vec;
  logic [NUM_CPU*BP_W-1:0]           bp_ali_vec;
  logic [NUM_CPU*NUM_APR*DATA_W-1:0] apr_vec;

  logic [DATA_W-1:0] rword;

  assign grouping   = (cfg_rev >= REV_W'(2));
  assign cpu_ok     = (32'(cpu_idx) < NUM_CPU);
  assign wr_applied = wr_en && cpu_ok && (tgt != TGT_NONE);
  assign wr_ignored = wr_en && !wr_applied;

  bp_decode #(.NUM_APR(NUM_APR)) u_dec (
    .addr     (addr),
    .secure   (acc_secure),
    .sec_ext  (cfg_sec_ext),
    .grouping (grouping),
    .tgt      (tgt),
    .apr_idx  (apr_idx)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic we_c;
    assign we_c = wr_applied && (cpu_idx == CPU_W'(c));

    bp_cpu_bank #(.NUM_APR(NUM_APR)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_c),
      .tgt      (tgt),
      .apr_idx  (apr_idx),
      .wdata    (wdata),
      .pmr_q    (pmr_a[c]),
      .bp_pri_q (bp_pri_a[c]),
      .bp_ali_q (bp_ali_a[c]),
      .apr_q    (apr_a[c])
    );

    assign pmr_vec[c*PMR_W +: PMR_W]                      = pmr_a[c];
    assign bp_pri_vec[c*BP_W +: BP_W]                     = bp_pri_a[c];
    assign bp_ali_vec[c*BP_W +: BP_W]                     = bp_ali_a[c];
    assign apr_vec[c*NUM_APR*DATA_W +: NUM_APR*DATA_W]    = apr_a[c];
  end

  logic [PMR_W-1:0]          sel_pmr;
  logic [BP_W-1:0]           sel_pri;
  logic [BP_W-1:0]           sel_ali;
  logic [NUM_APR*DATA_W-1:0] sel_apr;
  tgt_e                      rd_tgt;

  always_comb begin
    sel_pmr = '0;
    sel_pri = '0;
    sel_ali = '0;
    sel_apr = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_idx == CPU_W'(c)) begin
        sel_pmr = pmr_a[c];
        sel_pri = bp_pri_a[c];
        sel_ali = bp_ali_a[c];
        sel_apr = apr_a[c];
      end
    end
  end

  assign rd_tgt = cpu_ok ? tgt : TGT_NONE;

  bp_read_mux #(.NUM_APR(NUM_APR)) u_rmux (
    .tgt     (rd_tgt),
    .apr_idx (apr_idx),
    .pmr     (sel_pmr),
    .bp_pri  (sel_pri),
    .bp_ali  (sel_ali),
    .apr     (sel_apr),
    .rword   (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rword;
  end
endmodule

// File: rtl/bp_bank_chk.sv
module bp_bank_chk
  import bpr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_APR = 4,
  parameter int REV_W   = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cfg_sec_ext,
  input logic [REV_W-1:0]                  cfg_rev,
  input logic                              rd_en,
  input logic                              wr_en,
  input logic [OFF_W-1:0]                  addr,
  input logic [CPU_W-1:0]                  cpu_idx,
  input logic                              acc_secure,
  input logic [DATA_W-1:0]                 rdata,
  input logic                              wr_ignored,
  input logic [NUM_CPU*PMR_W-1:0]          pmr_vec,
  input logic [NUM_CPU*BP_W-1:0]           bp_pri_vec,
  input logic [NUM_CPU*BP_W-1:0]           bp_ali_vec,
  input logic [NUM_CPU*NUM_APR*DATA_W-1:0] apr_vec
);
  logic alias_off;
  assign alias_off = (addr == OFF_ABP) &&
                     ((cfg_rev < REV_W'(2)) || (cfg_sec_ext && !acc_secure));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr < OFF_APR0) |=> rdata[DATA_W-1:PMR_W] == '0);

  // R4
  pri_banked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == OFF_BP) && cfg_sec_ext && !acc_secure |=> $stable(bp_pri_vec));

  // R6
  alias_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && alias_off |=> rdata == '0);

  // R5
  alias_wi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && alias_off |=> $stable(bp_ali_vec) && $stable(bp_pri_vec));

  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(pmr_vec) && $stable(bp_pri_vec) &&
                   $stable(bp_ali_vec) && $stable(apr_vec));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_floor
    // R7
    alias_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_ali_vec[c*BP_W +: BP_W] != '0);
  end
endmodule

bind bp_bank_regs bp_bank_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_APR (NUM_APR),
  .REV_W   (REV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_sec_ext (cfg_sec_ext),
  .cfg_rev     (cfg_rev),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .addr        (addr),
  .cpu_idx     (cpu_idx),
  .acc_secure  (acc_secure),
  .rdata       (rdata),
  .wr_ignored  (wr_ignored),
  .pmr_vec     (pmr_vec),
  .bp_pri_vec  (bp_pri_vec),
  .bp_ali_vec  (bp_ali_vec),
  .apr_vec     (apr_vec)
);

// File: tb/tb_bp_bank_regs.sv
module tb_bp_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sec_ext = 1'b0;
  logic [1:0]  cfg_rev = 2'd2;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  cpu_idx = '0;
  logic        acc_secure = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bp_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .cfg_sec_ext(cfg_sec_ext), .cfg_rev(cfg_rev),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .cpu_idx(cpu_idx),
    .acc_secure(acc_secure), .wdata(wdata), .rdata(rdata)
  );

  // Bench model of the banked storage
  logic [7:0]  m_pmr [4];
  logic [2:0]  m_pri [4];
  logic [2:0]  m_ali [4];
  logic [31:0] m_apr [4][4];

  function automatic bit is_apr(input logic [11:0] a);
    return a >= 12'h0D0 && a <= 12'h0DC && a[1:0] == 2'b00;
  endfunction

  function automatic bit hides_alias(input logic sec);
    return (cfg_rev < 2) || (cfg_sec_ext && !sec);
  endfunction

  function automatic logic [31:0] exp_read(input int c, input logic [11:0] a, input logic sec);
    if (a == 12'h004) return {24'd0, m_pmr[c]};
    if (a == 12'h008) return (cfg_sec_ext && !sec) ? {29'd0, m_ali[c]} : {29'd0, m_pri[c]};
    if (a == 12'h01C) return hides_alias(sec) ? 32'd0 : {29'd0, m_ali[c]};
    if (is_apr(a)) return m_apr[c][(a - 12'h0D0) >> 2];
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [11:0] a, input logic sec);
    if (a == 12'h004) return "R2";
    if (a == 12'h008) return (cfg_sec_ext && !sec) ? "R4" : "R3";
    if (a == 12'h01C) return (cfg_rev < 2) ? "R5" : ((cfg_sec_ext && !sec) ? "R6" : "R7");
    if (is_apr(a)) return "R8";
    return "R10";
  endfunction

  function automatic logic [2:0] floor1(input logic [31:0] d);
    return (d[2:0] == 3'd0) ? 3'd1 : d[2:0];
  endfunction

  task automatic model_write(input int c, input logic [11:0] a, input logic sec, input logic [31:0] d);
    if (a == 12'h004) m_pmr[c] = d[7:0];
    else if (a == 12'h008) begin
      if (cfg_sec_ext && !sec) m_ali[c] = floor1(d);
      else m_pri[c] = d[2:0];
    end else if (a == 12'h01C) begin
      if (!hides_alias(sec)) m_ali[c] = floor1(d);
    end else if (is_apr(a)) m_apr[c][(a - 12'h0D0) >> 2] = d;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int c, input logic [11:0] a, input logic sec, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; cpu_idx = 2'(c); addr = a; acc_secure = sec; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(c, a, sec, d);
  endtask

  task automatic do_read(input int c, input logic [11:0] a, input logic sec, input string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; cpu_idx = 2'(c); addr = a; acc_secure = sec;
    e = exp_read(c, a, sec);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, e);
  endtask

  localparam logic [11:0] ADDRS [12] = '{12'h004, 12'h008, 12'h01C, 12'h0D0, 12'h0D4,
                                         12'h0D8, 12'h0DC, 12'h000, 12'h00C, 12'h0E0,
                                         12'h009, 12'h0D2};

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20150505));
    for (int c = 0; c < 4; c++) begin
      m_pmr[c] = 0; m_pri[c] = 0; m_ali[c] = 1;
      for (int w = 0; w < 4; w++) m_apr[c][w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset rdata", rdata, 32'd0);

    // R1: reset contents, viewed through the ports
    cfg_sec_ext = 1'b1; cfg_rev = 2'd2;
    for (int c = 0; c < 4; c++) begin
      do_read(c, 12'h008, 1'b1, "R1 primary");
      do_read(c, 12'h01C, 1'b1, "R1 alias");
      do_read(c, 12'h004, 1'b1, "R1 mask");
      do_read(c, 12'h0DC, 1'b1, "R1 apr");
    end

    // R4/R3: banking and floors
    do_write(0, 12'h008, 1'b0, 32'hFFFF_FFF8);
    do_read(0, 12'h008, 1'b0, "R4 clamp to 1");
    do_read(0, 12'h008, 1'b1, "R4 primary untouched");
    do_write(0, 12'h008, 1'b1, 32'h0000_0000);
    do_read(0, 12'h008, 1'b1, "R3 zero kept");
    do_write(0, 12'h008, 1'b1, 32'h0000_00F5);
    do_read(0, 12'h008, 1'b1, "R3 low bits");
    do_read(0, 12'h01C, 1'b1, "R7 secure sees ns copy");
    // R6
    do_write(0, 12'h01C, 1'b0, 32'd6);
    do_read(0, 12'h01C, 1'b0, "R6 raz");
    do_read(0, 12'h01C, 1'b1, "R6 wi");
    // R7
    do_write(0, 12'h01C, 1'b1, 32'd0);
    do_read(0, 12'h008, 1'b0, "R7 floor via alias");
    // R5
    cfg_rev = 2'd1;
    do_write(1, 12'h01C, 1'b1, 32'd7);
    do_read(1, 12'h01C, 1'b1, "R5 raz");
    cfg_rev = 2'd2;
    do_read(1, 12'h01C, 1'b1, "R5 wi");
    // R9
    do_write(1, 12'h0D4, 1'b1, 32'hDEAD_BEEF);
    do_write(1, 12'h004, 1'b1, 32'h1234_56A5);
    do_read(0, 12'h0D4, 1'b1, "R9 other cpu apr");
    do_read(2, 12'h004, 1'b1, "R9 other cpu mask");
    do_read(1, 12'h0D4, 1'b1, "R8 apr word 1");
    // R11: hold through idle and through a write
    do_read(1, 12'h004, 1'b1, "R2 mask");
    do_write(1, 12'h004, 1'b1, 32'h0000_0033);
    repeat (2) @(negedge clk);
    check("R11 hold", rdata, 32'h0000_00A5);
    // R11: read and write in one cycle returns the old value
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; cpu_idx = 2'd1; addr = 12'h004; acc_secure = 1'b1; wdata = 32'h77;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R11 read before write", rdata, 32'h33);
    model_write(1, 12'h004, 1'b1, 32'h77);
    // R10
    do_write(2, 12'h0D2, 1'b1, 32'hFFFF_FFFF);
    do_read(2, 12'h0D0, 1'b1, "R10 unaligned ignored");

    // Constrained random mix
    for (int i = 0; i < 1500; i++) begin
      int c;
      logic [11:0] a;
      logic s;
      if (i % 100 == 0) begin
        @(negedge clk);
        cfg_sec_ext = 1'($urandom_range(0, 1));
        cfg_rev = 2'($urandom_range(1, 2));
      end
      c = int'($urandom_range(0, 3));
      a = ADDRS[$urandom_range(0, 11)];
      s = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) do_write(c, a, s, $urandom);
      else do_read(c, a, s, tag_of(a, s));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule